// File: doc/BRIEF.md
# Indirect Statistics Memory Access Port

This block gives a management processor word-wide access to a statistics memory that it cannot address directly. The processor sees six 16-bit registers on a small parallel bus with an active-low select and an active-low ready. It places the target location (statistic, port and controller fields, plus a direction bit) into a select register, leaves write data in a data register if needed, and sets a go bit. The block then performs one memory access on the processor's behalf and clears the go bit when done.

The memory is shared with a statistics engine that performs read-modify-write updates. The engine requests ownership with `stat_req` and keeps it while it holds the request. A pending processor access waits for the engine to finish its current update and is served before the engine is granted again. Completion and misuse are recorded in a read-to-clear status register whose bits, gated by a mask register, drive an active-low interrupt.

The bus front end has two states: BUS_IDLE (waiting for select; leaves on select low) and BUS_HOLD (ready driven low; returns to BUS_IDLE when select goes high). The access sequencer has four: SQ_IDLE (go pending moves to SQ_ISSUE, otherwise a statistics request moves to SQ_STAT), SQ_STAT (engine owns the memory; a dropped request moves to SQ_ISSUE if go is pending, else to SQ_IDLE), SQ_ISSUE (one memory strobe cycle; always moves to SQ_DATA) and SQ_DATA (waits the memory latency, then completes and returns to SQ_IDLE).

Top module: `scp_top`

## Requirements
- R1: `cpu_addr` is the word index (processor address bits 7 to 1), so register byte offsets are even: index 0 control (bit 1 = go), 1 status, 2 mask, 3 select, 4 write data, 5 read data; any other index reads as 0.
- R2: `cpu_rdy_n` goes low in the cycle after `cpu_cs_n` is sampled low, stays low while `cpu_cs_n` stays low and returns high the cycle after `cpu_cs_n` is sampled high; `cpu_rdata` holds the addressed register while ready is low, and each select assertion performs exactly one register action.
- R3: Writing 1 to control bit 1 while no access is pending starts an access; the bit reads 1 until the access completes and the block then clears it.
- R4: In the select register bits [4:0] pick the statistic, bit 7 is the direction (1 = read, 0 = write), bits [11:8] the port and bits [15:12] the controller; the memory address is {controller, port, statistic}, 13 bits; bits 5 and 6 read 0.
- R5: A write access drives exactly one cycle of `mem_en` with `mem_we` high and `mem_wdata` equal to the write-data register.
- R6: A read access drives one cycle of `mem_en` with `mem_we` low and loads `mem_rdata`, sampled MEM_LAT cycles after that cycle, into the read-data register.
- R7: `stat_gnt` and `mem_en` are never high together; a granted engine keeps the grant while `stat_req` is high; a pending processor access waits while the grant is held and, once the request drops, is issued before the engine is granted again.
- R8: When a pending go bit and a statistics request meet in SQ_IDLE, the processor access is issued first.
- R9: A write to the select register while go is 1 leaves it unchanged and sets status bit 1, which stays set until read.
- R10: Completion sets status bit 0; mask bits [1:0] match the status bits; `irq_n` is low exactly when some status bit and its mask bit are both 1.
- R11: Reading the status register returns its bits and clears those that were set.
- R12: After reset ready and interrupt are high, grant and memory strobe are low, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs_n | input | 1 | Active-low register select |
| cpu_we | input | 1 | 1 = register write, 0 = register read |
| cpu_addr | input | 7 | Register word index |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data, valid while ready is low |
| cpu_rdy_n | output | 1 | Active-low ready |
| irq_n | output | 1 | Active-low interrupt |
| stat_req | input | 1 | Statistics engine memory request |
| stat_gnt | output | 1 | Statistics engine owns the memory |
| mem_en | output | 1 | Memory strobe for the processor access |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |

## Verification
The bench builds the block with MEM_LAT set to 3 instead of the default 1, so every access spends several cycles in SQ_DATA and the read-data capture must wait for the delayed memory output. That longer window lets a status read, a select write and a dropped-then-reasserted statistics request land while an access is in flight, which exercises the busy guard and the grant ordering.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int REG_W  = 16;
    localparam int REG_AW = 7;

    // register word indices
    localparam logic [REG_AW-1:0] RI_CTRL = 7'd0;
    localparam logic [REG_AW-1:0] RI_STAT = 7'd1;
    localparam logic [REG_AW-1:0] RI_MASK = 7'd2;
    localparam logic [REG_AW-1:0] RI_SEL  = 7'd3;
    localparam logic [REG_AW-1:0] RI_WDAT = 7'd4;
    localparam logic [REG_AW-1:0] RI_RDAT = 7'd5;

    localparam int GO_BIT = 1;

    // select register fields
    localparam int SF_STAT_LSB = 0;
    localparam int SF_STAT_W   = 5;
    localparam int SF_DIR_BIT  = 7;
    localparam int SF_PORT_LSB = 8;
    localparam int SF_PORT_W   = 4;
    localparam int SF_UNIT_LSB = 12;
    localparam int SF_UNIT_W   = 4;
    localparam int MEM_AW      = SF_STAT_W + SF_PORT_W + SF_UNIT_W;
    localparam logic [REG_W-1:0] SEL_KEEP = 16'hFF9F;

    // status / mask bits
    localparam int IB_DONE = 0;
    localparam int IB_ERR  = 1;
    localparam int IB_N    = 2;

    typedef enum logic [0:0] {BUS_IDLE, BUS_HOLD} bus_st_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_STAT, SQ_ISSUE, SQ_DATA} seq_st_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [REG_AW-1:0] idx;
        logic [REG_W-1:0]  data;
    } reg_acc_t;

endpackage

// File: rtl/scp_bus.sv
module scp_bus
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  rd_val,
    output reg_acc_t          acc,
    output logic              rdy_n,
    output logic [REG_W-1:0]  rdata
);

    bus_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (!cs_n) st_d = BUS_HOLD;
            BUS_HOLD: if (cs_n)  st_d = BUS_IDLE;
            default:             st_d = BUS_IDLE;
        endcase
    end

    // one action per select assertion, on the first sampled cycle
    always_comb begin
        acc.wr   = (st_q == BUS_IDLE) && !cs_n && we;
        acc.rd   = (st_q == BUS_IDLE) && !cs_n && !we;
        acc.idx  = addr;
        acc.data = wdata;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
            rdata <= '0;
        end else begin
            rdy_n <= (st_d != BUS_HOLD);
            if (st_q == BUS_IDLE && !cs_n) rdata <= rd_val;
        end
    end

endmodule

// File: rtl/scp_seq.sv
module scp_seq
    import scp_pkg::*;
#(
    parameter int MEM_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic stat_req,
    output logic stat_gnt,
    output logic mem_en,
    output logic done
);

    localparam int CNT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MEM_LAT - 1);

    seq_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_ISSUE)     cnt_q <= '0;
            else if (st_q == SQ_DATA) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (go)            st_d = SQ_ISSUE;
                else if (stat_req) st_d = SQ_STAT;
            end
            SQ_STAT: begin
                if (!stat_req) st_d = go ? SQ_ISSUE : SQ_IDLE;
            end
            SQ_ISSUE: st_d = SQ_DATA;
            SQ_DATA: begin
                if (cnt_q == CNT_LAST) st_d = SQ_IDLE;
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        stat_gnt = (st_q == SQ_STAT);
        mem_en   = (st_q == SQ_ISSUE);
        done     = (st_q == SQ_DATA) && (cnt_q == CNT_LAST);
    end

endmodule

// File: rtl/scp_regs.sv
module scp_regs
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_acc_t          acc,
    input  logic              done,
    input  logic [REG_W-1:0]  mem_rdata,
    output logic              go,
    output logic [REG_W-1:0]  sel,
    output logic [REG_W-1:0]  wdat,
    output logic [REG_W-1:0]  rd_val,
    output logic              irq_n
);

    logic [IB_N-1:0] stat_q, mask_q, set_v, clr_v;
    logic [REG_W-1:0] rdat_q;
    logic             go_q;

    always_comb begin
        set_v          = '0;
        set_v[IB_DONE] = done;
        set_v[IB_ERR]  = acc.wr && (acc.idx == RI_SEL) && go_q;
        clr_v          = (acc.rd && acc.idx == RI_STAT) ? stat_q : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            stat_q <= '0;
            mask_q <= '0;
            sel    <= '0;
            wdat   <= '0;
            rdat_q <= '0;
        end else begin
            if (done)
                go_q <= 1'b0;
            else if (acc.wr && acc.idx == RI_CTRL && acc.data[GO_BIT])
                go_q <= 1'b1;
            stat_q <= (stat_q & ~clr_v) | set_v;
            if (acc.wr && acc.idx == RI_MASK) mask_q <= acc.data[IB_N-1:0];
            if (acc.wr && acc.idx == RI_SEL && !go_q) sel <= acc.data & SEL_KEEP;
            if (acc.wr && acc.idx == RI_WDAT) wdat <= acc.data;
            if (done && sel[SF_DIR_BIT]) rdat_q <= mem_rdata;
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (acc.idx)
            RI_CTRL: rd_val[GO_BIT]   = go_q;
            RI_STAT: rd_val[IB_N-1:0] = stat_q;
            RI_MASK: rd_val[IB_N-1:0] = mask_q;
            RI_SEL:  rd_val           = sel;
            RI_WDAT: rd_val           = wdat;
            RI_RDAT: rd_val           = rdat_q;
            default: rd_val           = '0;
        endcase
    end

    assign go    = go_q;
    assign irq_n = ~|(stat_q & mask_q);

endmodule

// File: rtl/scp_top.sv
module scp_top
    import scp_pkg::*;
#(
    parameter int MEM_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs_n,
    input  logic              cpu_we,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              cpu_rdy_n,
    output logic              irq_n,
    input  logic              stat_req,
    output logic              stat_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [REG_W-1:0]  mem_wdata,
    input  logic [REG_W-1:0]  mem_rdata
);

    reg_acc_t         acc;
    logic [REG_W-1:0] rd_val, sel, wdat;
    logic             go, done;

    scp_bus u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cpu_cs_n),
        .we     (cpu_we),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .rd_val (rd_val),
        .acc    (acc),
        .rdy_n  (cpu_rdy_n),
        .rdata  (cpu_rdata)
    );

    scp_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .done      (done),
        .mem_rdata (mem_rdata),
        .go        (go),
        .sel       (sel),
        .wdat      (wdat),
        .rd_val    (rd_val),
        .irq_n     (irq_n)
    );

    scp_seq #(.MEM_LAT(MEM_LAT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .stat_req (stat_req),
        .stat_gnt (stat_gnt),
        .mem_en   (mem_en),
        .done     (done)
    );

    assign mem_we    = mem_en && !sel[SF_DIR_BIT];
    assign mem_addr  = {sel[SF_UNIT_LSB +: SF_UNIT_W],
                        sel[SF_PORT_LSB +: SF_PORT_W],
                        sel[SF_STAT_LSB +: SF_STAT_W]};
    assign mem_wdata = wdat;

endmodule

// File: rtl/scp_chk.sv
module scp_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_cs_n,
    input logic cpu_rdy_n,
    input logic stat_req,
    input logic stat_gnt,
    input logic mem_en
);

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_gnt && mem_en));

    p_gnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_gnt && stat_req) |=> stat_gnt);

    p_gnt_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_gnt) |-> $past(stat_req));

    p_rdy_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rdy_n) |-> $past(!cpu_cs_n));

    p_rdy_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs_n && !cpu_rdy_n) |=> cpu_rdy_n);

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

endmodule

bind scp_top scp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_cs_n  (cpu_cs_n),
    .cpu_rdy_n (cpu_rdy_n),
    .stat_req  (stat_req),
    .stat_gnt  (stat_gnt),
    .mem_en    (mem_en)
);

// File: tb/sim_scp_top.sv
`timescale 1ns/1ps
module sim_scp_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs_n = 1'b1;
    logic        cpu_we = 1'b0;
    logic [6:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_rdy_n, irq_n, stat_gnt, mem_en, mem_we;
    logic        stat_req = 1'b0;
    logic [12:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] sram_q;

    int checks = 0;
    int errors = 0;
    int strobes = 0;

    always #2.5 clk = ~clk;

    scp_top #(.MEM_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_cs_n(cpu_cs_n), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rdy_n(cpu_rdy_n), .irq_n(irq_n), .stat_req(stat_req),
        .stat_gnt(stat_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(sram_q)
    );

    // memory with LAT cycles of read latency
    logic [15:0] smem [int];
    logic [15:0] rd_sr [LAT];
    assign sram_q = rd_sr[LAT-1];

    always @(posedge clk) begin
        if (mem_en) strobes <= strobes + 1;
        if (mem_en && mem_we) smem[int'(mem_addr)] = mem_wdata;
        rd_sr[0] <= (mem_en && !mem_we) ?
                    (smem.exists(int'(mem_addr)) ? smem[int'(mem_addr)] : 16'h0) : 16'hDEAD;
        for (int i = 1; i < LAT; i++) rd_sr[i] <= rd_sr[i-1];
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    int          m_st, m_cnt;
    logic        m_go, m_bus;
    logic [1:0]  m_stat, m_mask;
    logic [15:0] m_sel, m_wd, m_rd, m_cap;

    always @(posedge clk) begin : ref_model
        logic stb, wr, rd, fin, errs;
        int nst;
        logic [15:0] rb;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_go = 0; m_bus = 0; m_stat = 0; m_mask = 0;
            m_sel = 0; m_wd = 0; m_rd = 0; m_cap = 0;
        end else begin
            stb = !m_bus && !cpu_cs_n;
            wr  = stb && cpu_we;
            rd  = stb && !cpu_we;
            fin = (m_st == 3) && (m_cnt == LAT-1);
            case (cpu_addr)
                7'd0: rb = {14'd0, m_go, 1'b0};
                7'd1: rb = {14'd0, m_stat};
                7'd2: rb = {14'd0, m_mask};
                7'd3: rb = m_sel;
                7'd4: rb = m_wd;
                7'd5: rb = m_rd;
                default: rb = 16'h0;
            endcase
            nst = m_st;
            if (m_st == 0) nst = m_go ? 2 : (stat_req ? 1 : 0);
            else if (m_st == 1) nst = stat_req ? 1 : (m_go ? 2 : 0);
            else if (m_st == 2) nst = 3;
            else if (fin) nst = 0;
            if (m_st == 2) m_cnt = 0; else if (m_st == 3) m_cnt++;
            if (fin && m_sel[7]) m_rd = sram_q;
            errs = wr && cpu_addr == 7'd3 && m_go;
            m_stat = (m_stat & ~((rd && cpu_addr == 7'd1) ? m_stat : 2'b00)) | {errs, fin};
            if (wr && cpu_addr == 7'd2) m_mask = cpu_wdata[1:0];
            if (wr && cpu_addr == 7'd3 && !m_go) m_sel = cpu_wdata & 16'hFF9F;
            if (wr && cpu_addr == 7'd4) m_wd = cpu_wdata;
            if (fin) m_go = 0;
            else if (wr && cpu_addr == 7'd0 && cpu_wdata[1]) m_go = 1;
            if (stb) begin m_bus = 1; m_cap = rb; end
            else if (m_bus && cpu_cs_n) m_bus = 0;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 ready", cpu_rdy_n, !m_bus);
            chk("R10 irq", irq_n, ~|(m_stat & m_mask));
            chk("R7 grant", stat_gnt, m_st == 1);
            chk("R5 strobe", mem_en, m_st == 2);
            if (m_st == 2) begin
                chk("R5 direction", mem_we, !m_sel[7]);
                chk("R4 address", mem_addr, {m_sel[15:12], m_sel[11:8], m_sel[4:0]});
                if (!m_sel[7]) chk("R5 wdata", mem_wdata, m_wd);
            end
            if (m_bus) chk("R2 rdata", cpu_rdata, m_cap);
        end
    end

    task automatic cpu_write(input logic [6:0] a, input logic [15:0] d);
        cpu_cs_n = 0; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            if (!cpu_rdy_n) break;
            @(negedge clk);
        end
        cpu_cs_n = 1;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [6:0] a, output logic [15:0] d);
        cpu_cs_n = 0; cpu_we = 0; cpu_addr = a;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            if (!cpu_rdy_n) break;
            @(negedge clk);
        end
        d = cpu_rdata;
        cpu_cs_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_go_clear();
        logic [15:0] v;
        v = 16'h2;
        for (int k = 0; k < 200; k++) begin
            cpu_read(7'd0, v);
            if (!v[1]) break;
        end
        chk("R3 go cleared by block", v[1], 1'b0);
    endtask

    initial begin : wdog
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 ready high", cpu_rdy_n, 1'b1);
        chk("R12 irq high", irq_n, 1'b1);
        chk("R12 grant low", stat_gnt, 1'b0);
        chk("R12 strobe low", mem_en, 1'b0);
        for (int r = 0; r < 6; r++) begin
            cpu_read(7'(r), v);
            chk("R12 register zero", v, 16'h0);
        end
        cpu_read(7'h10, v);
        chk("R1 unmapped reads zero", v, 16'h0);

        // R10 mask
        cpu_write(7'd2, 16'hFFFF);
        cpu_read(7'd2, v);
        chk("R10 mask width", v, 16'h0003);

        // R2 ready held while select held
        cpu_cs_n = 0; cpu_we = 0; cpu_addr = 7'd2;
        repeat (4) @(negedge clk);
        chk("R2 ready held", cpu_rdy_n, 1'b0);
        chk("R2 data held", cpu_rdata, 16'h0003);
        cpu_cs_n = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 ready released", cpu_rdy_n, 1'b1);

        // R4 R5 write access
        cpu_write(7'd3, 16'h1263);
        cpu_read(7'd3, v);
        chk("R4 select reserved bits zero", v, 16'h1203);
        cpu_write(7'd4, 16'hBEEF);
        cpu_write(7'd0, 16'h0002);
        wait_go_clear();
        chk("R5 memory written", smem.exists(32'h243) ? smem[32'h243] : 16'h0, 16'hBEEF);
        chk("R10 irq on completion", irq_n, 1'b0);
        cpu_read(7'd1, v);
        chk("R11 status done", v, 16'h0001);
        chk("R11 irq after clear", irq_n, 1'b1);
        cpu_read(7'd1, v);
        chk("R11 status cleared", v, 16'h0000);

        // R6 read access
        cpu_write(7'd3, 16'h1283);
        cpu_write(7'd0, 16'h0002);
        wait_go_clear();
        cpu_read(7'd5, v);
        chk("R6 read data", v, 16'hBEEF);
        smem[32'h1FFF] = 16'h5A5A;
        cpu_write(7'd3, 16'hFF9F);
        cpu_write(7'd0, 16'h0002);
        wait_go_clear();
        cpu_read(7'd5, v);
        chk("R4 field corners read", v, 16'h5A5A);
        cpu_read(7'd1, v);

        // R10 masked completion
        cpu_write(7'd2, 16'h0000);
        cpu_write(7'd0, 16'h0002);
        wait_go_clear();
        chk("R10 masked irq stays high", irq_n, 1'b1);
        cpu_read(7'd1, v);
        chk("R10 status set while masked", v, 16'h0001);

        // R7 R9 arbitration and busy guard
        stat_req = 1;
        repeat (2) @(negedge clk);
        chk("R7 engine granted", stat_gnt, 1'b1);
        cpu_write(7'd3, 16'h0001);
        cpu_write(7'd4, 16'h1111);
        s0 = strobes;
        cpu_write(7'd0, 16'h0002);
        repeat (6) @(negedge clk);
        chk("R7 access waits for engine", strobes, s0);
        cpu_read(7'd0, v);
        chk("R3 go reads one while pending", v[1], 1'b1);
        cpu_write(7'd3, 16'h0F0F);
        cpu_read(7'd3, v);
        chk("R9 select unchanged when busy", v, 16'h0001);
        cpu_read(7'd1, v);
        chk("R9 error flag set", v, 16'h0002);
        stat_req = 0;
        @(negedge clk);
        stat_req = 1;
        chk("R7 access issued on release", mem_en, 1'b1);
        @(negedge clk);
        chk("R7 engine waits for access", stat_gnt, 1'b0);
        repeat (LAT + 3) @(negedge clk);
        chk("R7 engine regranted", stat_gnt, 1'b1);
        chk("R5 write under arbitration", smem.exists(1) ? smem[1] : 16'h0, 16'h1111);
        stat_req = 0;
        repeat (2) @(negedge clk);
        cpu_read(7'd1, v);

        // R8 priority in idle
        cpu_cs_n = 0; cpu_we = 1; cpu_addr = 7'd0; cpu_wdata = 16'h0002;
        @(negedge clk);
        stat_req = 1;
        cpu_cs_n = 1;
        @(negedge clk);
        chk("R8 processor first strobe", mem_en, 1'b1);
        chk("R8 engine not granted", stat_gnt, 1'b0);
        repeat (LAT + 3) @(negedge clk);
        chk("R8 engine granted after", stat_gnt, 1'b1);
        stat_req = 0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule